// File: doc/BRIEF.md
# Photoflash Charge and Trigger Supervisor

This block sequences the charging of a photoflash storage capacitor and decides when a flash trigger may reach the gate driver. A charge enable level from the host starts a charge run. The block then requests switching from the switch controller until that controller reports, with a one-cycle pulse, that the target voltage has been reached. An active-low done line reports completion. When the regulation strap allows it, the block starts a fresh top-up run each time an external droop comparator reports that the stored voltage has sagged.

Two trigger inputs must both be high to form a flash request. The request is blocked during the first charge after enable, so that switching noise cannot fire a half-charged tube. It passes freely in standby and once the capacitor is charged. A request that arrives during a top-up run stops switching at once. Switching stays stopped until the request goes away.

The charge enable and both trigger inputs are asynchronous and pass through two-flop synchronisers. The target pulse, the strap and the droop bit are taken as already synchronous to `clk_i`.

Top module: `flash_charge_sup`

## Requirements
- R1: After reset, with all inputs low, run_o is 0, done_no is 1 and drv_o is 0.
- R2: A low-to-high change of chg_en_i starts a charge run: run_o goes to 1 three clock edges after the change, while done_no stays 1.
- R3: A one-cycle target_hit_i pulse during a charge run ends it: from the next edge, run_o is 0 and done_no is 0.
- R4: With reg_off_i at 1, reg_low_i is ignored: no new run starts while done_no is 0, until chg_en_i is lowered and raised again.
- R5: While chg_en_i is low (after synchronisation), done_no is 1 and run_o is 0. A later rising edge of chg_en_i starts a new run.
- R6: With reg_off_i at 0 and done_no at 0, reg_low_i at 1 starts a top-up run (run_o at 1) while done_no stays 0. A target_hit_i pulse ends the run.
- R7: The effective trigger is trig_a_i AND trig_b_i. One input high on its own never drives drv_o.
- R8: Driver enable: it is on when chg_en_i is low, off when chg_en_i is high and done_no is 1, and on when chg_en_i is high and done_no is 0. A trigger during the first charge run does not stop that run.
- R9: An effective trigger during a top-up run drops run_o in the same cycle that the synchronised trigger rises. drv_o rises one edge later.
- R10: After a halt caused by a trigger, run_o stays 0 for as long as the effective trigger is high. The top-up run resumes one edge after the synchronised trigger falls.
- R11: drv_o equals the synchronised effective trigger AND driver enable, registered once. A trigger change at an input appears on drv_o exactly three clock edges later.
- R12: If reg_low_i is high while the effective trigger is high and done_no is 0, the top-up run is deferred until the trigger is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chg_en_i | input | 1 | Charge enable, asynchronous |
| trig_a_i | input | 1 | First flash trigger, asynchronous |
| trig_b_i | input | 1 | Second flash trigger, asynchronous |
| target_hit_i | input | 1 | One-cycle pulse from the switch controller: target voltage reached |
| reg_off_i | input | 1 | Strap: 1 disables automatic top-up |
| reg_low_i | input | 1 | Droop comparator: 1 when the stored voltage has sagged below the refresh level |
| run_o | output | 1 | Switching request to the switch controller |
| done_no | output | 1 | Active-low charge complete |
| drv_o | output | 1 | Gate driver drive |

## Verification
The hardest case to reach is a trigger that lands inside a top-up run. That run exists only after a full charge, with regulation enabled and the droop bit raised. The stimulus builds this sequence one step at a time with directed target pulses and droop pulses, then asserts both triggers at a known clock edge. It checks the exact cycle in which run_o drops and the cycle in which drv_o rises. It holds the trigger for a long stretch, then releases only one input to show the run resumes. Randomised trigger pairs are applied in standby, during the first charge and in the charged state, to cover every row of the enable table.

// File: rtl/flash_sup_pkg.sv
package flash_sup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CHARGE  = 3'd1,
    ST_HOLD    = 3'd2,
    ST_REFRESH = 3'd3,
    ST_HALT    = 3'd4
  } sup_state_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/fs_sync.sv
module fs_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fs_rise.sv
module fs_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/fs_charge_fsm.sv
module fs_charge_fsm
  import flash_sup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       en_rise_i,
  input  logic       trig_i,
  input  logic       hit_i,
  input  logic       reg_off_i,
  input  logic       reg_low_i,
  output logic       run_o,
  output logic       done_no,
  output sup_state_e state_o
);
  sup_state_e state_q, state_d;
  logic       charged;

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:    if (en_rise_i) state_d = ST_CHARGE;
        ST_CHARGE:  if (hit_i) state_d = ST_HOLD;
        ST_HOLD:    if (!reg_off_i && reg_low_i && !trig_i) state_d = ST_REFRESH;
        ST_REFRESH: begin
          if (trig_i)     state_d = ST_HALT;
          else if (hit_i) state_d = ST_HOLD;
        end
        ST_HALT:    if (!trig_i) state_d = ST_REFRESH;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // done stays asserted through top-up and halt so the driver remains enabled
  assign charged = (state_q == ST_HOLD) || (state_q == ST_REFRESH) || (state_q == ST_HALT);
  assign done_no = ~(en_i & charged);
  // trigger gates a refresh run combinationally for an immediate halt
  assign run_o   = en_i & ((state_q == ST_CHARGE) || ((state_q == ST_REFRESH) && !trig_i));
  assign state_o = state_q;

  p_halt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT && trig_i && en_i) |=> (state_q == ST_HALT));

  p_regoff_no_topup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && reg_off_i) |=> (state_q != ST_REFRESH));

  p_charge_needs_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_IDLE && state_q == ST_CHARGE) |-> $past(en_rise_i));
endmodule

// File: rtl/fs_interlock.sv
module fs_interlock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_a_i,
  input  logic trig_b_i,
  input  logic en_i,
  input  logic done_ni,
  output logic trig_o,
  output logic drv_o
);
  logic allow;
  logic drv_q;

  assign trig_o = trig_a_i & trig_b_i;
  assign allow  = ~en_i | ~done_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= 1'b0;
    else         drv_q <= trig_o & allow;
  end

  assign drv_o = drv_q;

  p_lock_first_charge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && done_ni) |=> !drv_q);

  p_drv_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> $past(trig_a_i && trig_b_i));
endmodule

// File: rtl/flash_charge_sup.sv
module flash_charge_sup
  import flash_sup_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chg_en_i,
  input  logic trig_a_i,
  input  logic trig_b_i,
  input  logic target_hit_i,
  input  logic reg_off_i,
  input  logic reg_low_i,
  output logic run_o,
  output logic done_no,
  output logic drv_o
);
  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] raw_in, syn_in;
  logic             en_s, en_rise, trig_eff, done_n;
  sup_state_e       state;

  assign raw_in = {trig_b_i, trig_a_i, chg_en_i};

  fs_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw_in), .q_o(syn_in)
  );

  assign en_s = syn_in[0];

  fs_rise u_rise (
    .clk_i, .rst_ni, .lvl_i(en_s), .rise_o(en_rise)
  );

  fs_charge_fsm u_fsm (
    .clk_i, .rst_ni,
    .en_i(en_s), .en_rise_i(en_rise), .trig_i(trig_eff),
    .hit_i(target_hit_i), .reg_off_i, .reg_low_i,
    .run_o, .done_no(done_n), .state_o(state)
  );

  fs_interlock u_lock (
    .clk_i, .rst_ni,
    .trig_a_i(syn_in[1]), .trig_b_i(syn_in[2]),
    .en_i(en_s), .done_ni(done_n),
    .trig_o(trig_eff), .drv_o
  );

  assign done_no = done_n;

  p_run_drv_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_o && drv_o));

  p_off_done_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_s) |-> (done_no && !run_o));

  p_single_trig_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!syn_in[1] || !syn_in[2]) |=> !drv_o);

  p_state_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state inside {ST_IDLE, ST_CHARGE, ST_HOLD, ST_REFRESH, ST_HALT});
endmodule

// File: tb/sim_flash_charge_sup.sv
module sim_flash_charge_sup;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic chg_en = 0, ta = 0, tb = 0, hit = 0, reg_off = 1, reg_low = 0;
  logic run, done_n, drv;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;

  always #4 clk = ~clk;

  flash_charge_sup u0 (
    .clk_i(clk), .rst_ni, .chg_en_i(chg_en), .trig_a_i(ta), .trig_b_i(tb),
    .target_hit_i(hit), .reg_off_i(reg_off), .reg_low_i(reg_low),
    .run_o(run), .done_no(done_n), .drv_o(drv)
  );

  function automatic logic exp_drv(logic en, logic dn, logic a, logic b);
    return (a & b) & (~en | ~dn);
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_hit();
    hit = 1; step(1); hit = 0;
  endtask

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    step(3); rst_ni = 1; step(1);
    chk("R1 run", run, 0); chk("R1 done_n", done_n, 1); chk("R1 drv", drv, 0);

    // standby: trigger AND and enable table row for chg_en low
    for (int i = 0; i < 20; i++) begin
      ta = 1'($urandom % 2); tb = 1'($urandom % 2); step(4);
      chk("R7 standby drv", drv, exp_drv(0, 1, ta, tb));
    end
    ta = 0; tb = 0; step(4);
    ta = 1; tb = 1; step(2);
    chk("R11 drv before 3rd edge", drv, 0);
    step(1);
    chk("R11 drv on 3rd edge", drv, 1);
    ta = 0; tb = 0; step(4);

    // first charge
    chg_en = 1; step(2);
    chk("R2 run before 3rd edge", run, 0);
    step(1);
    chk("R2 run", run, 1); chk("R2 done_n", done_n, 1);
    for (int i = 0; i < 10; i++) begin
      ta = 1'($urandom % 2); tb = 1'($urandom % 2); step(3 + ($urandom % 3));
      chk("R8 locked drv", drv, exp_drv(1, 1, ta, tb));
      chk("R8 run continues", run, 1);
    end
    ta = 0; tb = 0; step(4);
    pulse_hit();
    chk("R3 run", run, 0); chk("R3 done_n", done_n, 0);

    // regulation off: droop ignored
    reg_low = 1; step(6);
    chk("R4 run", run, 0); chk("R4 done_n", done_n, 0);
    reg_low = 0;
    for (int i = 0; i < 10; i++) begin
      ta = 1'($urandom % 2); tb = 1'($urandom % 2); step(4);
      chk("R8 charged drv", drv, exp_drv(1, 0, ta, tb));
    end
    ta = 0; tb = 0; step(4);

    // standby then restart
    chg_en = 0; step(4);
    chk("R5 done_n", done_n, 1); chk("R5 run", run, 0);
    chg_en = 1; step(4);
    chk("R5 restart run", run, 1);
    pulse_hit();

    // regulation on: top-up
    reg_off = 0;
    reg_low = 1; step(1); reg_low = 0;
    chk("R6 run", run, 1); chk("R6 done_n", done_n, 0);
    step(3); pulse_hit();
    chk("R6 run end", run, 0);

    // droop while trigger held: deferred
    ta = 1; tb = 1; step(4);
    chk("R12 drv", drv, 1);
    reg_low = 1; step(5);
    chk("R12 deferred", run, 0);
    ta = 0; tb = 0; step(2);
    chk("R12 still deferred", run, 0);
    step(1);
    chk("R12 resumed", run, 1);
    reg_low = 0; step(2); pulse_hit();

    // trigger during a top-up run
    reg_low = 1; step(1); reg_low = 0; step(1);
    chk("R9 run before trig", run, 1);
    ta = 1; tb = 1; step(1);
    chk("R9 run one edge", run, 1);
    step(1);
    chk("R9 run halted", run, 0); chk("R9 drv not yet", drv, 0);
    step(1);
    chk("R9 drv fires", drv, 1); chk("R9 done_n", done_n, 0);
    step(20);
    chk("R10 held off", run, 0);
    ta = 0; step(2);
    chk("R10 not yet", run, 0);
    step(1);
    chk("R10 resumed", run, 1); chk("R10 drv", drv, 0);
    pulse_hit();
    chk("R6 done after", done_n, 0);

    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule